// File: doc/BRIEF.md
# Page-Aligned Flash Program Sequencer

This block writes a byte stream into a serial NOR flash. A request carries a start address and a byte length, and the payload arrives on a valid/ready stream. The sequencer cuts the request into pieces so that no piece crosses a page boundary. For each piece it runs the same steps. It sets the write-enable latch and waits for the device to go idle. It confirms that the latch reads back as set. It sends the program frame with the payload. It then polls the status register, with a fixed pause between reads, until the busy flag drops.

Frames go out one byte at a time on a command-engine port. `eng_last` marks the final byte of a frame, and the engine releases chip select after that byte. For a status-read frame, the engine returns the byte it clocked in on `eng_rx_valid`/`eng_rx_byte`. The sequencer finishes each request with a one-cycle `done` pulse and a result code.

Top module: `flash_prog_seq`

## Requirements
- R1: Each program piece has length min(remaining, PAGE_BYTES - (address mod PAGE_BYTES)). Successive pieces continue at the next address until the request is used up.
- R2: Before every piece, the block sends a one-byte write-enable frame (0x06). It then reads status (frame 0x05, 0x00), repeating the read while bit 0 is set.
- R3: If that status read shows bit 0 clear and bit 1 (write-enable latch) clear, the request ends with err_code 1. No program frame is sent.
- R4: A program frame is 0x02, then ADDR_BYTES address bytes most significant first, then the piece's data bytes in stream order. Data moves only when the engine accepts it. The data source must hold `din_valid` until it is accepted.
- R5: After each program frame, status is read until bit 0 clears. If MAX_POLLS reads in one wait all show bit 0 set, the request ends with err_code 2.
- R6: After a status read that shows bit 0 set, the block keeps `eng_valid` low for more than POLL_GAP cycles before the next frame.
- R7: A request of length 0 gives `done` in the next cycle with err_code 0 and no engine traffic.
- R8: After an error, no further frame byte is offered.
- R9: Out of reset, `req_ready` is 1, `done` is 0, err_code is 0, and `eng_valid` and `din_ready` are 0.
- R10: `req_ready` is low while a request is in progress. `done` is asserted only while idle, and err_code is 0 when the request succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Idle, accepts a request |
| req_addr | input | 8*ADDR_BYTES | Start byte address |
| req_len | input | LEN_W | Byte count |
| din_valid | input | 1 | Payload byte available |
| din_ready | output | 1 | Payload byte consumed |
| din_data | input | 8 | Payload byte |
| eng_valid | output | 1 | Frame byte offered to the engine |
| eng_ready | input | 1 | Engine takes the byte |
| eng_byte | output | 8 | Frame byte |
| eng_last | output | 1 | Final byte of the frame |
| eng_rx_valid | input | 1 | Status byte returned |
| eng_rx_byte | input | 8 | Returned status byte |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 latch not set, 2 busy timeout |

## Verification
The assertions check several properties on every cycle:
- an offered frame byte is held stable until the engine accepts it;
- payload moves only on engine acceptance;
- the engine port is quiet while idle;
- the pause after a busy status read is kept;
- nothing is offered after an error.

Other behaviour shows up only in the bench's scenarios. This covers how pieces are cut around page edges and the exact bytes of each program frame. It also covers the write-enable count per piece and the two error codes under a modelled device. The zero-length shortcut is checked there too.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WREN,
        ST_SR_OP,
        ST_SR_DUM,
        ST_SR_WAIT,
        ST_GAP,
        ST_PP_OP,
        ST_PP_ADDR,
        ST_PP_DATA
    } fps_state_e;

    typedef enum logic [1:0] {
        FPS_OK       = 2'd0,
        FPS_ERR_WEL  = 2'd1,
        FPS_ERR_BUSY = 2'd2
    } fps_err_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
        logic       last;
    } fps_tx_t;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam int SR_WIP_BIT = 0;
    localparam int SR_WEL_BIT = 1;

endpackage

// File: rtl/fps_chunk_calc.sv
module fps_chunk_calc #(
    parameter int PAGE_BYTES = 256,
    parameter int LEN_W      = 16,
    localparam int PG_W      = $clog2(PAGE_BYTES)
) (
    input  logic [PG_W-1:0]  addr_lo,
    input  logic [LEN_W-1:0] remain,
    output logic [LEN_W-1:0] chunk
);
    logic [LEN_W-1:0] room;

    always_comb begin
        room  = LEN_W'(PAGE_BYTES) - LEN_W'(addr_lo);
        chunk = (remain < room) ? remain : room;
    end
endmodule

// File: rtl/fps_poll_ctl.sv
module fps_poll_ctl #(
    parameter int MAX_POLLS = 10000,
    parameter int POLL_GAP  = 16,
    localparam int PW       = $clog2(MAX_POLLS + 1),
    localparam int GW       = $clog2(POLL_GAP + 2)
) (
    input  logic clk,
    input  logic rst,
    input  logic cnt_clr,
    input  logic cnt_inc,
    output logic at_limit,
    output logic gap_zero
);
    logic [PW-1:0] cnt_q;
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            gap_q <= '0;
        end else begin
            if (cnt_clr)
                cnt_q <= '0;
            else if (cnt_inc)
                cnt_q <= cnt_q + 1'b1;
            if (cnt_inc)
                gap_q <= GW'(POLL_GAP);
            else if (gap_q != '0)
                gap_q <= gap_q - 1'b1;
        end
    end

    assign at_limit = (cnt_q == PW'(MAX_POLLS - 1));
    assign gap_zero = (gap_q == '0);
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import fps_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int ADDR_BYTES = 3,
    parameter int LEN_W      = 16,
    parameter int MAX_POLLS  = 10000,
    parameter int POLL_GAP   = 16,
    localparam int ADDR_W    = 8 * ADDR_BYTES,
    localparam int PG_W      = $clog2(PAGE_BYTES),
    localparam int AIW       = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              din_valid,
    output logic              din_ready,
    input  logic [7:0]        din_data,
    output logic              eng_valid,
    input  logic              eng_ready,
    output logic [7:0]        eng_byte,
    output logic              eng_last,
    input  logic              eng_rx_valid,
    input  logic [7:0]        eng_rx_byte,
    output logic              done,
    output logic [1:0]        err_code
);
    fps_state_e       state_q;
    fps_err_e         err_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0] remain_q, chunk_q, chunk_nx;
    logic [AIW-1:0]   aidx_q;
    logic             post_q, done_q;
    logic             hs, cnt_clr, cnt_inc, at_limit, gap_zero;
    logic             sr_wip, sr_wel, sr_unused;
    fps_tx_t          tx;

    assign sr_wip    = eng_rx_byte[SR_WIP_BIT];
    assign sr_wel    = eng_rx_byte[SR_WEL_BIT];
    assign sr_unused = ^eng_rx_byte[7:2];

    fps_chunk_calc #(.PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W)) u_chunk (
        .addr_lo (addr_q[PG_W-1:0]),
        .remain  (remain_q),
        .chunk   (chunk_nx)
    );

    fps_poll_ctl #(.MAX_POLLS(MAX_POLLS), .POLL_GAP(POLL_GAP)) u_poll (
        .clk      (clk),
        .rst      (rst),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .at_limit (at_limit),
        .gap_zero (gap_zero)
    );

    always_comb begin
        tx        = '{valid: 1'b0, data: 8'h00, last: 1'b0};
        din_ready = 1'b0;
        case (state_q)
            ST_WREN:    tx = '{valid: 1'b1, data: OP_WREN, last: 1'b1};
            ST_SR_OP:   tx = '{valid: 1'b1, data: OP_RDSR, last: 1'b0};
            ST_SR_DUM:  tx = '{valid: 1'b1, data: 8'h00,   last: 1'b1};
            ST_PP_OP:   tx = '{valid: 1'b1, data: OP_PROG, last: 1'b0};
            ST_PP_ADDR: tx = '{valid: 1'b1, data: addr_q[8*aidx_q +: 8], last: 1'b0};
            ST_PP_DATA: begin
                tx        = '{valid: din_valid, data: din_data, last: (chunk_q == LEN_W'(1))};
                din_ready = eng_ready;
            end
            default: ;
        endcase
    end

    assign eng_valid = tx.valid;
    assign eng_byte  = tx.data;
    assign eng_last  = tx.last;
    assign hs        = tx.valid && eng_ready;
    assign req_ready = (state_q == ST_IDLE);
    assign done      = done_q;
    assign err_code  = err_q;

    assign cnt_clr = hs && ((state_q == ST_WREN) ||
                            (state_q == ST_PP_DATA && chunk_q == LEN_W'(1)));
    assign cnt_inc = (state_q == ST_SR_WAIT) && eng_rx_valid && sr_wip && !at_limit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            err_q    <= FPS_OK;
            addr_q   <= '0;
            remain_q <= '0;
            chunk_q  <= '0;
            aidx_q   <= '0;
            post_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    err_q <= FPS_OK;
                    if (req_len == '0) begin
                        done_q <= 1'b1;
                    end else begin
                        addr_q   <= req_addr;
                        remain_q <= req_len;
                        state_q  <= ST_WREN;
                    end
                end
                ST_WREN: if (hs) begin
                    post_q  <= 1'b0;
                    state_q <= ST_SR_OP;
                end
                ST_SR_OP:  if (hs) state_q <= ST_SR_DUM;
                ST_SR_DUM: if (hs) state_q <= ST_SR_WAIT;
                ST_SR_WAIT: if (eng_rx_valid) begin
                    if (sr_wip) begin
                        if (at_limit) begin
                            err_q   <= FPS_ERR_BUSY;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_GAP;
                        end
                    end else if (!post_q) begin
                        if (!sr_wel) begin
                            err_q   <= FPS_ERR_WEL;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            chunk_q <= chunk_nx;
                            aidx_q  <= AIW'(ADDR_BYTES - 1);
                            state_q <= ST_PP_OP;
                        end
                    end else if (remain_q == '0) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_WREN;
                    end
                end
                ST_GAP:   if (gap_zero) state_q <= ST_SR_OP;
                ST_PP_OP: if (hs) state_q <= ST_PP_ADDR;
                ST_PP_ADDR: if (hs) begin
                    if (aidx_q == '0) state_q <= ST_PP_DATA;
                    else              aidx_q  <= aidx_q - 1'b1;
                end
                ST_PP_DATA: if (hs) begin
                    chunk_q  <= chunk_q - 1'b1;
                    remain_q <= remain_q - 1'b1;
                    addr_q   <= addr_q + 1'b1;
                    if (chunk_q == LEN_W'(1)) begin
                        post_q  <= 1'b1;
                        state_q <= ST_SR_OP;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
    parameter int POLL_GAP = 16,
    localparam int CW      = $clog2(POLL_GAP + 3)
) (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       eng_valid,
    input logic       eng_ready,
    input logic [7:0] eng_byte,
    input logic       eng_last,
    input logic       eng_rx_valid,
    input logic       rx_wip,
    input logic       din_ready,
    input logic       done,
    input logic [1:0] err_code
);
    logic [CW-1:0] since_busy;
    logic          armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_busy <= '0;
            armed      <= 1'b0;
        end else if (eng_rx_valid && rx_wip) begin
            since_busy <= '0;
            armed      <= 1'b1;
        end else begin
            if (since_busy != '1) since_busy <= since_busy + 1'b1;
            if (eng_valid) armed <= 1'b0;
        end
    end

    AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (rst)
        eng_valid && !eng_ready |=> eng_valid && $stable(eng_byte) && $stable(eng_last)); // R4
    AST_DATA_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        din_ready |-> eng_ready); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !eng_valid && !din_ready); // R9
    AST_POLL_GAP: assert property (@(posedge clk) disable iff (rst)
        eng_valid && armed |-> since_busy > CW'(POLL_GAP)); // R6
    AST_STOP_AFTER_ERR: assert property (@(posedge clk) disable iff (rst)
        done && err_code != 2'd0 |=> !eng_valid); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> req_ready); // R10
endmodule

bind flash_prog_seq fps_checker #(.POLL_GAP(POLL_GAP)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_ready    (req_ready),
    .eng_valid    (eng_valid),
    .eng_ready    (eng_ready),
    .eng_byte     (eng_byte),
    .eng_last     (eng_last),
    .eng_rx_valid (eng_rx_valid),
    .rx_wip       (eng_rx_byte[0]),
    .din_ready    (din_ready),
    .done         (done),
    .err_code     (err_code)
);

// File: tb/flash_prog_seq_tb.sv
module flash_prog_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PAGE = 16;
    localparam int MAXP = 6;
    localparam int GAP  = 2;
    localparam int NVEC = 7;

    // addr, len, busy reads after program, latch blocked, ready mode, expected err
    typedef struct packed {
        logic [23:0] addr;
        logic [15:0] len;
        logic [7:0]  busy;
        logic        welblk;
        logic        rmode;
        logic [1:0]  err;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{24'h000010, 16'd16, 8'd1, 1'b0, 1'b0, 2'd0},
        '{24'h00000C, 16'd10, 8'd0, 1'b0, 1'b0, 2'd0},
        '{24'h0000F5, 16'd40, 8'd2, 1'b0, 1'b1, 2'd0},
        '{24'h123456, 16'd3,  8'd5, 1'b0, 1'b1, 2'd0},
        '{24'h000020, 16'd20, 8'd6, 1'b0, 1'b0, 2'd2},
        '{24'h000008, 16'd5,  8'd0, 1'b1, 1'b0, 2'd1},
        '{24'h0000FF, 16'd2,  8'd0, 1'b0, 1'b1, 2'd0}
    };

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_ready;
    logic [23:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic din_valid, din_ready;
    logic [7:0] din_data;
    logic eng_valid, eng_ready, eng_last;
    logic [7:0] eng_byte;
    logic eng_rx_valid = 0;
    logic [7:0] eng_rx_byte = '0;
    logic done;
    logic [1:0] err_code;

    int total = 0, bad = 0;
    bit fin = 0;
    int cyc = 0;
    int din_idx = 0, din_off = 0, cur_len = 0, cur_addr = 0;
    int cfg_busy = 0;
    bit cfg_welblk = 0, cfg_rmode = 0;

    int fidx = 0, tot_bytes = 0, wren_cnt = 0, pp_cnt = 0, data_bad = 0, proto_bad = 0;
    bit wel = 0;
    int busy_left = 0;
    logic [7:0] fbuf [32];
    int pp_addr [64];
    int pp_len  [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 7 + 60);
    endfunction

    assign din_valid = (din_idx - din_off) < cur_len;
    assign din_data  = pat(din_idx - din_off);
    assign eng_ready = !cfg_rmode || (cyc % 3 != 0);

    flash_prog_seq #(.PAGE_BYTES(PAGE), .ADDR_BYTES(3), .LEN_W(16),
                     .MAX_POLLS(MAXP), .POLL_GAP(GAP)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .din_valid(din_valid),
        .din_ready(din_ready), .din_data(din_data), .eng_valid(eng_valid),
        .eng_ready(eng_ready), .eng_byte(eng_byte), .eng_last(eng_last),
        .eng_rx_valid(eng_rx_valid), .eng_rx_byte(eng_rx_byte),
        .done(done), .err_code(err_code)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (din_valid && din_ready) din_idx <= din_idx + 1;
    end

    // device model on the engine port
    always @(posedge clk) begin
        eng_rx_valid <= 1'b0;
        if (!rst && eng_valid && eng_ready) begin
            tot_bytes = tot_bytes + 1;
            fbuf[fidx] = eng_byte;
            fidx = fidx + 1;
            if (eng_last) begin
                case (fbuf[0])
                    8'h06: begin wren_cnt = wren_cnt + 1; wel = !cfg_welblk; end
                    8'h05: begin
                        eng_rx_byte  <= {6'b0, wel, busy_left > 0};
                        eng_rx_valid <= 1'b1;
                        if (busy_left > 0) busy_left = busy_left - 1;
                    end
                    8'h02: begin
                        if (!wel || fidx < 5) proto_bad = proto_bad + 1;
                        pp_addr[pp_cnt] = {8'h00, fbuf[1], fbuf[2], fbuf[3]};
                        pp_len[pp_cnt]  = fidx - 4;
                        for (int j = 4; j < fidx; j++)
                            if (fbuf[j] != pat(pp_addr[pp_cnt] + j - 4 - cur_addr))
                                data_bad = data_bad + 1;
                        pp_cnt = pp_cnt + 1;
                        wel = 0;
                        busy_left = cfg_busy;
                    end
                    default: proto_bad = proto_bad + 1;
                endcase
                fidx = 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_req(input vec_t v);
        int t, b_pp, b_wren, b_data, b_proto, b_bytes, a, r, c, k, nch, exp_pp;
        @(negedge clk);
        cfg_busy = int'(v.busy); cfg_welblk = v.welblk; cfg_rmode = v.rmode;
        b_pp = pp_cnt; b_wren = wren_cnt; b_data = data_bad; b_proto = proto_bad; b_bytes = tot_bytes;
        din_off = din_idx; cur_len = int'(v.len); cur_addr = int'(v.addr);
        req_addr = v.addr; req_len = v.len; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        if (v.len != 0) check(req_ready == 0, "R10 busy hides req_ready", req_ready, 0);
        t = 0;
        while (!done && t < 20000) begin @(negedge clk); t++; end
        check(done == 1, "R10 done seen", done, 1);
        check(err_code == v.err, "R3/R5 err_code", err_code, v.err);
        // expected pieces
        a = int'(v.addr); r = int'(v.len); nch = 0;
        while (r > 0) begin
            c = PAGE - (a % PAGE); if (r < c) c = r;
            if (v.err == 0 || (v.err == 2 && nch == 0))
                if (b_pp + nch < pp_cnt) begin
                    check(pp_addr[b_pp+nch] == a, "R1/R4 piece address", pp_addr[b_pp+nch], a);
                    check(pp_len[b_pp+nch] == c, "R1 piece length", pp_len[b_pp+nch], c);
                end
            a += c; r -= c; nch++;
        end
        exp_pp = (v.err == 0) ? nch : (v.err == 2 ? 1 : 0);
        check(pp_cnt - b_pp == exp_pp, "R1 piece count", pp_cnt - b_pp, exp_pp);
        k = (v.err == 0) ? nch : 1;
        check(wren_cnt - b_wren == k, "R2 write-enable per piece", wren_cnt - b_wren, k);
        check(data_bad == b_data, "R4 data bytes", data_bad - b_data, 0);
        check(proto_bad == b_proto, "R2 program only with latch set", proto_bad - b_proto, 0);
        b_bytes = tot_bytes;
        repeat (30) @(negedge clk);
        check(tot_bytes == b_bytes, "R8 no traffic after finish", tot_bytes - b_bytes, 0);
        cur_len = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(req_ready == 1, "R9 reset req_ready", req_ready, 1);
        check(eng_valid == 0, "R9 reset eng_valid", eng_valid, 0);
        check(din_ready == 0, "R9 reset din_ready", din_ready, 0);
        check(done == 0, "R9 reset done", done, 0);
        check(err_code == 0, "R9 reset err_code", err_code, 0);

        for (int i = 0; i < NVEC; i++) run_req(VECS[i]);

        // R7: zero length request
        begin
            int b0;
            b0 = tot_bytes;
            @(negedge clk);
            req_addr = 24'h000040; req_len = 0; cur_len = 0; req_valid = 1;
            @(negedge clk);
            req_valid = 0;
            check(done == 1, "R7 zero length done next cycle", done, 1);
            check(err_code == 0, "R7 zero length err_code", err_code, 0);
            @(negedge clk);
            check(done == 0, "R7 done is a pulse", done, 0);
            check(tot_bytes == b0, "R7 no engine bytes", tot_bytes - b0, 0);
        end

        // R5: busy for MAXP-1 reads still succeeds, boundary
        run_req('{24'h000030, 16'd4, 8'(MAXP-1), 1'b0, 1'b0, 2'd0});
        // R5 and R8: timeout on second piece not reached since first fails
        run_req('{24'h00003E, 16'd6, 8'(MAXP), 1'b0, 1'b1, 2'd2});

        fin = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule